// File: doc/BRIEF.md
# Changeover Pushbutton Debouncer with Press Counter

This block turns a bouncing changeover pushbutton into one clean level and counts complete presses. The button's moving contact rests on a normally-closed pole and moves to a normally-open pole when pushed. Each pole reaches the block as an active-low input, which reads 1 while its contact is open. The contacts break before they make, so while the contact travels both inputs read 1.

Both inputs first pass through a synchroniser chain. They then drive a registered set/reset state. The normally-closed pole sets the state and the normally-open pole resets it. A change happens only when the opposite pole is first touched, so any bounce on the pole that is already in contact has no effect. A rising edge of the state advances a binary counter. One full press and release therefore adds exactly one. A synchronous clear returns the counter to zero and the level to its idle value.

Top module: `twocontact_debounce`

## Requirements
- R1: When both contact inputs read 1 (storage), the internal level keeps its previous value.
- R2: With the normally-closed input at 0 and the normally-open input at 1, the level becomes 1 (`level_q`=1, `level_q_n`=0). This is also the idle rest value.
- R3: With the normally-open input at 0 and the normally-closed input at 1, the level becomes 0 (`level_q`=0, `level_q_n`=1).
- R4: Repeated bounce between storage and the pole that last drove the level does not change the level or the count.
- R5: `press_count` rises by exactly one for each 0-to-1 change of the level. A 1-to-0 change leaves it unchanged.
- R6: While both inputs read 0, `level_q` and `level_q_n` both read 1 and `contact_fault` reads 1. The internal level is held, and it reappears on the outputs once the inputs return to storage.
- R7: `press_count` wraps from its maximum value (15 at the default width) to 0 on the next rising edge.
- R8: A synchronous clear (`cnt_clr`=1) sets `press_count` to 0 and the level to 1. The level change this causes does not count.
- R9: While `rst_n` is 0 at a clock edge, the outputs become `level_q`=1, `level_q_n`=0, `contact_fault`=0, `press_count`=0.
- R10: A change on a contact input reaches `level_q` on the third rising clock edge, through two synchroniser flops and the state register. The matching count change appears one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nc_contact_n | input | 1 | Normally-closed pole, active low (sets the level) |
| no_contact_n | input | 1 | Normally-open pole, active low (resets the level) |
| cnt_clr | input | 1 | Synchronous clear of the counter and the level |
| level_q | output | 1 | Debounced level (1 = button idle) |
| level_q_n | output | 1 | Complement of the level (1 with `level_q` while faulted) |
| contact_fault | output | 1 | Both poles read closed at once |
| press_count | output | CNT_W | Count of completed presses |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a 4-bit counter. With a 4-bit counter, sixteen press/release cycles reach the wrap from 15 to 0 in a short run. Two stages give a fixed three-edge latency, which the bench measures one edge at a time. Single-cycle contact pulses still pass the synchroniser, so the bench can show that a one-clock touch of the opposite pole is enough to flip the level, and that later pulses on the same pole change nothing.

// File: rtl/dbnc_pkg.sv
// Shared types for the changeover pushbutton debouncer.
// Assumes contact inputs are active low and already synchronised.
package dbnc_pkg;

    // Four possible combinations of the two synchronised contact inputs.
    typedef enum logic [1:0] {
        CT_STORE = 2'b00,   // neither pole touched: hold
        CT_SET   = 2'b01,   // normally-closed pole touched
        CT_RESET = 2'b10,   // normally-open pole touched
        CT_BOTH  = 2'b11    // both touched: invalid
    } contact_e;

    // Map the active-low pole levels onto a contact condition.
    function automatic contact_e decode_contacts(input logic set_n, input logic reset_n);
        return contact_e'({~reset_n, ~set_n});
    endfunction

endpackage

// File: rtl/dbnc_sync_chain.sv
// Multi-flop synchroniser for one asynchronous contact input.
// Resets to 1 (contact open), so nothing looks touched straight after reset.
// Assumes STAGES >= 2.
module dbnc_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/dbnc_sr_state.sv
// Registered set/reset state that mimics a cross-coupled gate latch.
// Set on the normally-closed pole and reset on the normally-open pole.
// Holds in storage and while both poles are touched. Clear forces it to 1.
// Assumes synchronised active-low inputs.
module dbnc_sr_state
    import dbnc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_n,
    input  logic reset_n,
    input  logic clr,
    output logic state,
    output logic fault
);
    contact_e cond;

    assign cond  = decode_contacts(set_n, reset_n);
    assign fault = (cond == CT_BOTH);

    // Update the stored level from the contact condition.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= 1'b1;
        end else begin
            unique case (cond)
                CT_SET:   state <= 1'b1;
                CT_RESET: state <= 1'b0;
                default:  state <= state;
            endcase
        end
    end

    a_r1_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_n && reset_n && !clr) |=> (state == $past(state)));
    a_r2_set_drives_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_n && reset_n) |=> state);
    a_r3_reset_drives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (set_n && !reset_n && !clr) |=> !state);
    a_r6_both_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_n && !reset_n && !clr) |=> (state == $past(state)));
    a_r8_clear_sets: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state);
endmodule

// File: rtl/dbnc_edge_counter.sv
// Binary up counter that advances once per rising edge of a level.
// Clear zeroes the count and primes the edge history to 1, so the clear's
// own rise of the level is not counted. Wraps at 2**CNT_W.
module dbnc_edge_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    logic level_d;
    logic rise;

    assign rise = level & ~level_d;

    // Remember the level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) level_d <= 1'b1;
        else               level_d <= level;
    end

    // Advance the count on each rising edge; wrap naturally.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (rise)     count <= count + 1'b1;
    end

    a_r5_step_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && level && !level_d) |=> (count == $past(count) + 1'b1));
    a_r5_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(level && !level_d)) |=> $stable(count));
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/twocontact_debounce.sv
// Changeover pushbutton debouncer with a press counter.
// Synchronises both active-low poles, keeps a set/reset level and counts
// its rising edges. While both poles read closed, both level outputs read 1
// and the fault flag is raised; the stored level is kept.
module twocontact_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nc_contact_n,
    input  logic             no_contact_n,
    input  logic             cnt_clr,
    output logic             level_q,
    output logic             level_q_n,
    output logic             contact_fault,
    output logic [CNT_W-1:0] press_count
);
    localparam int N_POLES = 2;

    logic [N_POLES-1:0] raw_n;
    logic [N_POLES-1:0] synced_n;
    logic               state;
    logic               fault;

    assign raw_n = {no_contact_n, nc_contact_n};

    // One synchroniser per pole.
    for (genvar p = 0; p < N_POLES; p++) begin : g_sync
        dbnc_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (raw_n[p]),
            .d_sync  (synced_n[p])
        );
    end

    dbnc_sr_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_n   (synced_n[0]),
        .reset_n (synced_n[1]),
        .clr     (cnt_clr),
        .state   (state),
        .fault   (fault)
    );

    dbnc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .level (state),
        .clr   (cnt_clr),
        .count (press_count)
    );

    // Both outputs read 1 while the poles are both closed.
    assign level_q       = state | fault;
    assign level_q_n     = ~state | fault;
    assign contact_fault = fault;

    a_r6_fault_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        contact_fault |-> (level_q && level_q_n));
    a_r2_outputs_complement: assert property (@(posedge clk) disable iff (!rst_n)
        !contact_fault |-> (level_q != level_q_n));
endmodule

// File: tb/twocontact_debounce_tb.sv
module twocontact_debounce_tb;
    localparam int CNT_W = 4;
    localparam int NVEC  = 20;
    localparam int HOLD  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nc_n = 1'b0;
    logic no_n = 1'b1;
    logic clr = 1'b0;
    logic q, qn, flt;
    logic [CNT_W-1:0] cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    twocontact_debounce u_dut (
        .clk (clk), .rst_n (rst_n),
        .nc_contact_n (nc_n), .no_contact_n (no_n), .cnt_clr (clr),
        .level_q (q), .level_q_n (qn), .contact_fault (flt), .press_count (cnt)
    );

    // Row: {nc_n, no_n, clr}, {level_q, level_q_n, contact_fault}, count
    localparam logic [9:0] VEC [NVEC] = '{
        {3'b010, 3'b100, 4'd0},  // idle rest
        {3'b110, 3'b100, 4'd0},  // travel, hold 1
        {3'b100, 3'b010, 4'd0},  // press touches NO
        {3'b110, 3'b010, 4'd0},  // bounce
        {3'b100, 3'b010, 4'd0},
        {3'b110, 3'b010, 4'd0},
        {3'b010, 3'b100, 4'd1},  // release: one count
        {3'b110, 3'b100, 4'd1},
        {3'b010, 3'b100, 4'd1},  // bounce on NC
        {3'b110, 3'b100, 4'd1},
        {3'b100, 3'b010, 4'd1},
        {3'b010, 3'b100, 4'd2},
        {3'b000, 3'b111, 4'd2},  // both closed while level 1
        {3'b110, 3'b100, 4'd2},
        {3'b100, 3'b010, 4'd2},
        {3'b000, 3'b111, 4'd2},  // both closed while level 0
        {3'b110, 3'b010, 4'd2},  // level 0 kept
        {3'b111, 3'b100, 4'd0},  // clear
        {3'b110, 3'b100, 4'd0},
        {3'b010, 3'b100, 4'd0}
    };

    function automatic string row_req(input int i);
        case (i)
            0, 19:            return "R2";
            1, 13:            return "R1";
            2, 10, 14:        return "R3";
            3, 4, 5, 8, 9:    return "R4";
            6, 7, 11:         return "R5";
            12, 15, 16:       return "R6";
            default:          return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic outs(input string req, input logic eq, input logic eqn,
                        input logic ef, input logic [CNT_W-1:0] ec);
        check(req, 16'({q, qn, flt, cnt}), 16'({eq, eqn, ef, ec}));
    endtask

    task automatic drive(input logic a, input logic b, input int n);
        nc_n = a; no_n = b;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        outs("R9", 1'b1, 1'b0, 1'b0, 4'd0);   // reset state
        rst_n = 1'b1;
        repeat (HOLD) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            nc_n = VEC[i][9]; no_n = VEC[i][8]; clr = VEC[i][7];
            repeat (HOLD) @(negedge clk);
            outs(row_req(i), VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
        end

        // R10: latency of a press, then of a release and its count
        drive(1'b1, 1'b0, 2);
        check("R10", 16'(q), 16'(1'b1));
        @(negedge clk);
        check("R10", 16'(q), 16'(1'b0));
        drive(1'b0, 1'b1, 3);
        check("R10", 16'({q, cnt}), 16'({1'b1, 4'd0}));
        @(negedge clk);
        check("R10", 16'(cnt), 16'd1);

        // R4: single-cycle pulses; first NO touch flips, repeats do not
        drive(1'b1, 1'b1, 4);
        drive(1'b1, 1'b0, 1);
        drive(1'b1, 1'b1, 5);
        check("R3", 16'(q), 16'(1'b0));
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 1'b0, 1);
            drive(1'b1, 1'b1, 2);
        end
        drive(1'b1, 1'b1, 4);
        check("R4", 16'({q, cnt}), 16'({1'b0, 4'd1}));
        drive(1'b0, 1'b1, 1);
        drive(1'b1, 1'b1, 5);
        check("R5", 16'({q, cnt}), 16'({1'b1, 4'd2}));

        // R7: walk through the wrap
        for (int k = 0; k < 16; k++) begin
            drive(1'b1, 1'b0, 5);
            drive(1'b0, 1'b1, 5);
            check(k == 13 ? "R7" : "R5", 16'(cnt), 16'((k + 3) % 16));
        end

        // R9: reset while pressed with a nonzero count
        drive(1'b1, 1'b0, 5);
        rst_n = 1'b0;
        @(negedge clk);
        outs("R9", 1'b1, 1'b0, 1'b0, 4'd0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 6);
        outs("R9", 1'b1, 1'b0, 1'b0, 4'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule